// File: doc/BRIEF.md
# Graphics DRAM special register loader

This block is the device-side command logic of a small synchronous graphics DRAM. It holds two side registers, a color register and a bit-mask register, next to a behavioural data array of 64 words of 16 bits. It decodes the command pins on every rising clock edge. A load-special command writes whichever side register the select address bits name, and it takes the value from the data input in that same edge. Array reads and writes run as sequential bursts of four or eight beats.

The side-register loads share the data pins with array bursts but do not depend on them. A load may be placed in the wait after a row activation, in the read latency window, or inside a read or write burst. The burst keeps its address sequence and its data. The byte masks apply to array traffic alone: they gate write beats one edge later and turn off read drivers two edges later. A masked write changes only the bits that are set in the mask register. The block raises sticky flags when a load carries an illegal address pattern and when a load meets a bus that the read drivers still hold.

Top module: `gfxram_loader`

## Requirements
- R1: After reset, dqOut, dqOe, colorReg, maskReg, illegalOp and contentionErr are all zero, and every array word reads as zero.
- R2: Commands are sampled on the rising edge. {csN,rasN,casN,weN} = 0011 is ACTIVE and captures the row from addr[1:0]. 0101 with dsf=0 is READ. 0100 is WRITE, and with dsf=1 it is a masked write. 0000 with dsf=1 is LOAD SPECIAL. READ and WRITE take the start column from addr[3:0], and the array word is {row, column}.
- R3: LOAD SPECIAL with addr[6]=1 and addr[5]=0 loads colorReg from dqIn at that edge. With addr[5]=1 and addr[6]=0 it loads maskReg. The new value is visible after that edge.
- R4: A LOAD SPECIAL is illegal when addr[5]==addr[6], or any of addr[4:0], addr[8:7] or ba is 1. An illegal load changes neither side register and sets illegalOp, which stays set until reset.
- R5: The value of dqm has no effect on a LOAD SPECIAL.
- R6: burstEight sampled with READ/WRITE picks a burst of 8 (1) or 4 (0) beats. Beat i uses column (start & ~(L-1)) | ((start+i) & (L-1)), so the burst wraps inside its aligned block.
- R7: Write beat i takes dqIn at edge E+i, where E is the WRITE edge. Byte lane b (bits 8b+7:8b) is left unwritten when dqm[b] was 1 at the edge before that beat (write mask latency one).
- R8: A masked write changes only those bits of the word whose maskReg bit is 1, in addition to the byte masking of R7.
- R9: Read latency is three. Beat i of a READ at edge E is driven after edge E+2+i, so it is sampled at E+3+i. dqOe stays zero after edges E and E+1.
- R10: dqm[b]=1 at edge t turns off lane b of the read beat driven after edge t+1 (read mask latency two). That lane then has dqOe[b]=0 and dqOut bits 8b+7:8b equal to 0.
- R11: A LOAD SPECIAL issued during a row-activate wait, a read latency window or a read or write burst changes neither the burst's column sequence nor its other beats.
- R12: A LOAD SPECIAL at an edge where dqOe is nonzero is not performed and sets contentionErr, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe command pin, active low |
| casN | input | 1 | Column strobe command pin, active low |
| weN | input | 1 | Write enable command pin, active low |
| dsf | input | 1 | Special function pin: selects masked write and load-special |
| ba | input | 1 | Bank address (must be 0 for a load) |
| addr | input | 9 | Address pins: row, column, or register select |
| burstEight | input | 1 | Burst of 8 when 1, burst of 4 when 0 |
| dqm | input | 2 | Byte-lane masks for array traffic |
| dqIn | input | 16 | Data into the device |
| dqOut | output | 16 | Read data out of the device |
| dqOe | output | 2 | Per-lane read driver enables |
| colorReg | output | 16 | Current color register |
| maskReg | output | 16 | Current bit-mask register |
| illegalOp | output | 1 | Sticky: an illegal load address pattern was seen |
| contentionErr | output | 1 | Sticky: a load met driven read data |

## Verification
The hardest case to reach from the ports is a load placed inside a read burst without a bus clash. The bench has to raise dqm exactly two edges before the load, so that the beat driven just ahead of the load edge has its drivers off. The beats on either side of that gap must still come out with the right data. The same read also carries a load inside the latency window and a single-lane mask one edge earlier. A second read then places a load on a driven beat, to show that the register is held and the sticky clash flag is set.

// File: rtl/gfxram_pkg.sv
package gfxram_pkg;
  parameter int DQ_W      = 16;
  parameter int ADDR_W    = 9;
  parameter int COL_W     = 4;
  parameter int ROW_W     = 2;
  parameter int CAS_LAT   = 3;
  parameter int SEL_LO    = 5;   // select pair is addr[SEL_LO+1:SEL_LO]
  parameter int MAX_BURST = 8;

  localparam int LANES     = DQ_W / 8;
  localparam int ARR_AW    = ROW_W + COL_W;
  localparam int ARR_DEPTH = 1 << ARR_AW;
  localparam int CNT_W     = $clog2(MAX_BURST);

  typedef struct packed {
    logic              rdBeat;
    logic              wrBeat;
    logic              maskedWr;
    logic [ARR_AW-1:0] beatAddr;
    logic              ldColor;
    logic              ldMask;
  } strobe_t;

  function automatic logic [DQ_W-1:0] laneBits(input logic [LANES-1:0] en);
    logic [DQ_W-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*8 +: 8] = {8{en[l]}};
    return r;
  endfunction
endpackage

// File: rtl/gfxram_ctrl.sv
module gfxram_ctrl
  import gfxram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              dsf,
  input  logic              ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burstEight,
  output strobe_t           strb,
  output logic              illegalOp
);
  localparam logic [ADDR_W-1:0] SEL_FIELD = ADDR_W'(3) << SEL_LO;

  logic cmdAct, cmdRd, cmdWr, cmdLd;
  logic selColor, selMask, restZero, ldOk;
  logic [ROW_W-1:0] rowReg, bRow;
  logic             bActive, bWrite, bMasked;
  logic [COL_W-1:0] bStart, bWrap, lenMask;
  logic [CNT_W-1:0] bCnt, bLast;

  function automatic logic [COL_W-1:0] wrapCol(input logic [COL_W-1:0] s,
                                               input logic [COL_W-1:0] off,
                                               input logic [COL_W-1:0] m);
    return (s & ~m) | ((s + off) & m);
  endfunction

  always_comb begin
    cmdAct   = !csN && !rasN &&  casN &&  weN;
    cmdRd    = !csN &&  rasN && !casN &&  weN && !dsf;
    cmdWr    = !csN &&  rasN && !casN && !weN;
    cmdLd    = !csN && !rasN && !casN && !weN && dsf;
    restZero = ((addr & ~SEL_FIELD) == '0) && !ba;
    selColor = !addr[SEL_LO] &&  addr[SEL_LO+1];
    selMask  =  addr[SEL_LO] && !addr[SEL_LO+1];
    ldOk     = cmdLd && restZero && (selColor || selMask);
    lenMask  = burstEight ? COL_W'(MAX_BURST-1) : COL_W'(MAX_BURST/2-1);
  end

  always_comb begin
    strb         = '0;
    strb.ldColor = ldOk && selColor;
    strb.ldMask  = ldOk && selMask;
    if (cmdRd || cmdWr) begin
      strb.rdBeat   = cmdRd;
      strb.wrBeat   = cmdWr;
      strb.maskedWr = cmdWr && dsf;
      strb.beatAddr = {rowReg, addr[COL_W-1:0]};
    end else if (bActive) begin
      strb.rdBeat   = !bWrite;
      strb.wrBeat   = bWrite;
      strb.maskedWr = bMasked;
      strb.beatAddr = {bRow, wrapCol(bStart, COL_W'(bCnt), bWrap)};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg <= '0; bRow <= '0; bActive <= 1'b0; bWrite <= 1'b0; bMasked <= 1'b0;
      bStart <= '0; bWrap <= '0; bCnt <= '0; bLast <= '0; illegalOp <= 1'b0;
    end else begin
      if (cmdAct) rowReg <= addr[ROW_W-1:0];
      if (cmdLd && !ldOk) illegalOp <= 1'b1;
      if (cmdRd || cmdWr) begin
        bActive <= 1'b1;
        bWrite  <= cmdWr;
        bMasked <= cmdWr && dsf;
        bStart  <= addr[COL_W-1:0];
        bRow    <= rowReg;
        bWrap   <= lenMask;
        bCnt    <= CNT_W'(1);
        bLast   <= CNT_W'(lenMask);
      end else if (bActive) begin
        if (bCnt == bLast) bActive <= 1'b0;
        else               bCnt    <= bCnt + CNT_W'(1);
      end
    end
  end

  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bActive |-> (bCnt != '0 && bCnt <= bLast)); // R6
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |=> illegalOp); // R4
endmodule

// File: rtl/gfxram_dp.sv
module gfxram_dp
  import gfxram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [LANES-1:0] dqm,
  input  logic [DQ_W-1:0]  dqIn,
  output logic [DQ_W-1:0]  dqOut,
  output logic [LANES-1:0] dqOe,
  output logic [DQ_W-1:0]  colorReg,
  output logic [DQ_W-1:0]  maskReg,
  output logic             contentionErr
);
  localparam int STAGES = CAS_LAT - 1;

  logic [DQ_W-1:0]              mem [ARR_DEPTH];
  logic [LANES-1:0]             dqmD1;
  logic [STAGES-1:0]            stVld;
  logic [STAGES-1:0][ARR_AW-1:0] stAddr;
  logic [DQ_W-1:0]              wrBits;
  logic                         busOn, ldAny;

  always_comb begin
    wrBits = laneBits(~dqmD1) & (strb.maskedWr ? maskReg : '1);
    busOn  = |dqOe;
    ldAny  = strb.ldColor || strb.ldMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < ARR_DEPTH; w++) mem[w] <= '0;
    end else if (strb.wrBeat) begin
      mem[strb.beatAddr] <= (mem[strb.beatAddr] & ~wrBits) | (dqIn & wrBits);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqmD1 <= '0; stVld <= '0; stAddr <= '0; dqOut <= '0; dqOe <= '0;
      colorReg <= '0; maskReg <= '0; contentionErr <= 1'b0;
    end else begin
      dqmD1     <= dqm;
      stVld[0]  <= strb.rdBeat;
      stAddr[0] <= strb.beatAddr;
      for (int s = 1; s < STAGES; s++) begin
        stVld[s]  <= stVld[s-1];
        stAddr[s] <= stAddr[s-1];
      end
      dqOe  <= {LANES{stVld[STAGES-1]}} & ~dqmD1;
      dqOut <= mem[stAddr[STAGES-1]] & laneBits({LANES{stVld[STAGES-1]}} & ~dqmD1);
      if (ldAny && busOn) contentionErr <= 1'b1;
      if (strb.ldColor && !busOn) colorReg <= dqIn;
      if (strb.ldMask  && !busOn) maskReg  <= dqIn;
    end
  end

  AST_COLOR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldColor && dqOe == '0) |=> colorReg == $past(dqIn)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldMask |=> $stable(maskReg)); // R3
  AST_DRIVE_AFTER_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe != '0) |-> $past(strb.rdBeat, CAS_LAT)); // R9
  AST_NO_LOAD_ON_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    (ldAny && dqOe != '0) |=> ($stable(colorReg) && $stable(maskReg) && contentionErr)); // R12
endmodule

// File: rtl/gfxram_loader.sv
module gfxram_loader
  import gfxram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              dsf,
  input  logic              ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burstEight,
  input  logic [LANES-1:0]  dqm,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut,
  output logic [LANES-1:0]  dqOe,
  output logic [DQ_W-1:0]   colorReg,
  output logic [DQ_W-1:0]   maskReg,
  output logic              illegalOp,
  output logic              contentionErr
);
  strobe_t strb;

  gfxram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .dsf(dsf), .ba(ba), .addr(addr), .burstEight(burstEight),
    .strb(strb), .illegalOp(illegalOp)
  );

  gfxram_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dqm(dqm), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe), .colorReg(colorReg), .maskReg(maskReg),
    .contentionErr(contentionErr)
  );
endmodule

// File: tb/gfxram_loader_test.sv
module gfxram_loader_test;
  import gfxram_pkg::*;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  row;
    logic [3:0]  col;
    logic        b8;
    logic [15:0] base;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'd0, 4'd0,  1'b0, 16'h1000}, '{2'd0, 4'd6,  1'b0, 16'h2000},
    '{2'd1, 4'd5,  1'b1, 16'h3000}, '{2'd1, 4'd12, 1'b1, 16'h4000},
    '{2'd2, 4'd3,  1'b0, 16'h5000}, '{2'd3, 4'd15, 1'b1, 16'h6000}};

  logic clk = 1'b0, rstN = 1'b0;
  logic csN, rasN, casN, weN, dsf, ba, burstEight;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  dqm;
  logic [DQ_W-1:0]   dqIn, dqOut, colorReg, maskReg;
  logic [LANES-1:0]  dqOe;
  logic illegalOp, contentionErr;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [15:0] expMem [64];
  logic [15:0] expColor, expMask;

  gfxram_loader uut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask
  task automatic drv(input logic c, input logic r, input logic ca, input logic w,
                     input logic d, input logic [ADDR_W-1:0] a);
    csN = c; rasN = r; casN = ca; weN = w; dsf = d; addr = a; ba = 1'b0;
  endtask
  task automatic nop; drv(0, 1, 1, 1, 0, '0); endtask
  task automatic activate(input int row); drv(0, 0, 1, 1, 0, ADDR_W'(row)); tick; nop; endtask
  task automatic loadSpecial(input logic [ADDR_W-1:0] a); drv(0, 0, 0, 0, 1, a); endtask

  function automatic int wcol(input int s, input int i, input bit b8);
    int m = b8 ? 7 : 3;
    return (s & ~m) | ((s + i) & m);
  endfunction

  task automatic writeBurst(input int row, input int col, input bit b8, input bit masked,
                            input logic [15:0] base, input int hit);
    int n = b8 ? 8 : 4;
    for (int i = 0; i < n; i++) begin
      if (i == 0) drv(0, 1, 0, 0, masked, ADDR_W'(col)); else nop;
      burstEight = b8;
      dqIn = base + 16'(i);
      dqm = (i + 1 == hit) ? 2'b11 : 2'b00;
      if (i != hit) begin
        int idx = row * 16 + wcol(col, i, b8);
        logic [15:0] bits = masked ? expMask : 16'hFFFF;
        expMem[idx] = (expMem[idx] & ~bits) | (dqIn & bits);
      end
      tick;
    end
    dqm = 2'b00; nop; tick;
  endtask

  task automatic readCheck(input int row, input int col, input bit b8, input string tag);
    int n = b8 ? 8 : 4;
    drv(0, 1, 0, 1, 0, ADDR_W'(col)); burstEight = b8; tick;
    nop; tick; tick;
    for (int i = 0; i < n; i++) begin
      check(tag, {16'h0, dqOut}, {16'h0, expMem[row * 16 + wcol(col, i, b8)]});
      check(tag, {30'h0, dqOe}, 32'h3);
      tick;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    nop; burstEight = 0; dqm = 0; dqIn = 0;
    for (int k = 0; k < 64; k++) expMem[k] = 16'h0;
    expColor = 0; expMask = 0;
    tick; tick;
    // R1 reset state
    check("R1 dqOe", {30'h0, dqOe}, 0);
    check("R1 color", {16'h0, colorReg}, 0);
    check("R1 mask", {16'h0, maskReg}, 0);
    check("R1 flags", {30'h0, illegalOp, contentionErr}, 0);
    rstN = 1'b1; tick;
    readCheck(0, 0, 0, "R1 array zero");

    // R2 R6 table of sequential bursts, both lengths, wrapping
    foreach (VECS[v]) begin
      activate(VECS[v].row); tick;
      writeBurst(VECS[v].row, VECS[v].col, VECS[v].b8, 0, VECS[v].base, -1);
      readCheck(VECS[v].row, VECS[v].col, VECS[v].b8, "R6 burst wrap");
    end

    // R3 R5 color load with dqm high
    loadSpecial(9'h040); dqIn = 16'hA5A5; dqm = 2'b11; tick;
    dqm = 0; nop; expColor = 16'hA5A5;
    check("R3 R5 color load", {16'h0, colorReg}, {16'h0, expColor});
    loadSpecial(9'h020); dqIn = 16'h00FF; tick; nop; expMask = 16'h00FF;
    check("R3 mask load", {16'h0, maskReg}, {16'h0, expMask});

    // R4 illegal patterns
    loadSpecial(9'h060); dqIn = 16'hDEAD; tick; nop;
    check("R4 flag", {31'h0, illegalOp}, 1);
    check("R4 color kept", {16'h0, colorReg}, {16'h0, expColor});
    check("R4 mask kept", {16'h0, maskReg}, {16'h0, expMask});
    loadSpecial(9'h041); tick; nop;
    check("R4 low bit set", {16'h0, colorReg}, {16'h0, expColor});
    loadSpecial(9'h040); ba = 1'b1; tick; nop;
    check("R4 bank set", {16'h0, colorReg}, {16'h0, expColor});

    // R8 masked write
    activate(2); tick;
    writeBurst(2, 8, 0, 0, 16'h1234, -1);
    writeBurst(2, 8, 0, 1, 16'hFF00, -1);
    readCheck(2, 8, 0, "R8 masked write");

    // R7 write mask latency one
    activate(3); tick;
    writeBurst(3, 0, 0, 0, 16'h7000, 2);
    readCheck(3, 0, 0, "R7 write dqm latency");

    // R11 load inside a write burst, beat under it masked
    drv(0, 1, 0, 0, 0, 9'd8); burstEight = 0; dqIn = 16'h7100; tick;
    expMem[3*16+8] = 16'h7100;
    nop; dqIn = 16'h7101; dqm = 2'b11; tick;
    expMem[3*16+9] = 16'h7101;
    loadSpecial(9'h040); dqIn = 16'hC0DE; dqm = 0; tick;
    nop; dqIn = 16'h7103; tick;
    expMem[3*16+11] = 16'h7103; expColor = 16'hC0DE;
    tick;
    check("R11 color in write burst", {16'h0, colorReg}, {16'h0, expColor});
    readCheck(3, 8, 0, "R11 write burst intact");

    // R11 load in activate wait
    activate(0);
    loadSpecial(9'h020); dqIn = 16'h0F0F; tick; nop; expMask = 16'h0F0F;
    check("R11 load in activate wait", {16'h0, maskReg}, {16'h0, expMask});

    // R9 R10 R11 read: latency, load in latency window, lane mask, load in gap
    drv(0, 1, 0, 1, 0, 9'd0); burstEight = 1; tick;             // after E
    check("R9 quiet E", {30'h0, dqOe}, 0);
    loadSpecial(9'h040); dqIn = 16'h5A5A; tick;                   // after E+1
    expColor = 16'h5A5A;
    check("R9 quiet E+1", {30'h0, dqOe}, 0);
    check("R11 load in latency", {16'h0, colorReg}, {16'h0, expColor});
    nop; dqm = 2'b01; tick;                                       // after E+2
    check("R9 beat0", {16'h0, dqOut}, {16'h0, expMem[0]});
    dqm = 0; tick;                                                // after E+3
    check("R10 lane off oe", {30'h0, dqOe}, 2);
    check("R10 lane off data", {16'h0, dqOut}, {16'h0, expMem[1] & 16'hFF00});
    dqm = 2'b11; tick;                                            // after E+4
    check("R9 beat2", {16'h0, dqOut}, {16'h0, expMem[2]});
    dqm = 0; tick;                                                // after E+5
    check("R10 beat3 off", {30'h0, dqOe}, 0);
    loadSpecial(9'h040); dqIn = 16'hBEEF; tick;                   // after E+6
    nop; expColor = 16'hBEEF;
    check("R11 load in read gap", {16'h0, colorReg}, {16'h0, expColor});
    check("R12 no clash", {31'h0, contentionErr}, 0);
    for (int i = 4; i < 8; i++) begin
      check("R11 read beat after load", {16'h0, dqOut}, {16'h0, expMem[i]});
      tick;
    end

    // R12 load on driven bus
    drv(0, 1, 0, 1, 0, 9'd0); burstEight = 0; tick;
    nop; tick; tick;
    loadSpecial(9'h040); dqIn = 16'h1111; tick; nop;
    check("R12 flag", {31'h0, contentionErr}, 1);
    check("R12 color held", {16'h0, colorReg}, {16'h0, expColor});
    tick; tick; tick;

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule